// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an addressing-mode code and the operand bytes of an instruction into the memory addresses a 16-bit processor with a 24-bit address space needs for its data operand. It also reports how many internal (idle) bus cycles the mode costs. The processor state it uses is sampled when a request is accepted: direct-page base, data bank, program bank and counter, stack pointer, both index registers, the accumulator and index width flags, and whether the access is a write. For each request it returns the address of the operand's low byte and of its high byte, the idle-cycle count and the updated program counter for immediate operands.

Indirect modes need a pointer from memory. For these the unit issues one byte request at a time on a simple request/valid port, assembles the pointer, and only then produces the final addresses. A one-cycle `done` pulse marks the result. Outside that pulse every result output reads zero.

The controller is a five-state machine:
- `S_IDLE` waits for `start`.
- From `S_IDLE`, the transition **accept-direct** goes to `S_DONE`, and **accept-indirect** goes to `S_PTR_LO`.
- `S_PTR_LO` moves to `S_PTR_HI` on **lo-byte-taken**.
- `S_PTR_HI` moves to `S_DONE` on **hi-byte-taken-short**, or to `S_PTR_BANK` on **hi-byte-taken-long**.
- `S_PTR_BANK` moves to `S_DONE` on **bank-byte-taken**.
- `S_DONE` always returns to `S_IDLE` through **finish**.
- Each pointer state stays where it is while `ptr_valid` is low.

Top module: `eag_unit`

## Requirements
- R1: A `start` seen high in the idle state is accepted at that clock edge, and the input values of that edge are captured. `start` is ignored while a request is in progress. For modes without a pointer, `done` is high for exactly the one cycle following the accepting edge. While `done` is low, `addr_lo`, `addr_hi`, `idle_cycles`, `pc_next` and `err` are all zero.
- R2: Indirect modes raise `ptr_req` with a bank-0 address in `ptr_addr` and hold both until `ptr_valid` is high at a clock edge. Pointer bytes are requested in order: low, high, then bank byte (long forms only). Each request address is the pointer base plus 0, 1 or 2, wrapped to 16 bits. The pointer base is:
  - `dp_reg+op_lo+x_reg` for mode 8;
  - `dp_reg+op_lo` for modes 9–12;
  - `sp_reg+op_lo` for mode 14.
  `done` is high in the cycle after the edge that takes the last byte.
- R3: Direct-page modes give `addr_lo = dp_reg+op_lo(+index)` wrapped to 16 bits in bank 0, and `addr_hi` = that sum +1, also wrapped to 16 bits. The index is none for mode 0, `x_reg` for mode 1 and `y_reg` for mode 2.
- R4: Any mode based on the direct page (0, 1, 2, 8, 9, 10, 11, 12) costs one idle cycle when `dp_reg[7:0]` is nonzero. Modes 1, 2 and 8 cost one further idle cycle in all cases.
- R5: Absolute mode 3 gives `addr_lo = {db_reg,16'h0}+{op_hi,op_lo}`. Modes 4 and 5 add `x_reg` and `y_reg` respectively. The sum wraps to 24 bits, and `addr_hi = addr_lo+1` wrapped to 24 bits.
- R6: Modes 4, 5 and 10 cost one idle cycle when `wr_access` is 1, or when `idx8` is 0, or when base+index (17-bit sum) differs from the base above bit 7. Otherwise these modes cost no such cycle. For mode 10 the base is the fetched 16-bit pointer and the index is `y_reg`.
- R7: Long mode 6 gives `addr_lo = {op_bank,op_hi,op_lo}`. Mode 7 adds `x_reg`. Both wrap to 24 bits, `addr_hi = addr_lo+1` wrapped to 24 bits, and there are 0 idle cycles.
- R8: Mode 8 (`(dp,X)`) and mode 9 (`(dp)`) give `addr_lo = {db_reg,16'h0}+pointer`. Mode 10 (`(dp),Y`) adds `y_reg` to that. All wrap to 24 bits with `addr_hi = addr_lo+1`.
- R9: Modes 11 and 12 fetch a 3-byte pointer. Mode 11 gives `addr_lo = pointer`; mode 12 gives `pointer+y_reg` wrapped to 24 bits. In both, `addr_hi = addr_lo+1` wrapped to 24 bits.
- R10: Mode 13 gives `addr_lo = sp_reg+op_lo` wrapped to 16 bits in bank 0, `addr_hi` = that value +1 wrapped to 16 bits, and 1 idle cycle. Mode 14 gives `addr_lo = {db_reg,16'h0}+pointer+y_reg` wrapped to 24 bits, `addr_hi = addr_lo+1`, and 2 idle cycles.
- R11: Mode 15 (immediate) gives `addr_lo = {pb_reg,pc_reg}`. The selected width flag is `idx8` when `imm_index` is 1 and `acc8` otherwise.
  - When the selected flag is 1, the operand is one byte: `addr_hi = 0` and `pc_next = pc_reg+1`.
  - When the flag is 0, the operand is two bytes: `addr_hi = {pb_reg,pc_reg+1}` and `pc_next = pc_reg+2`, both PC sums wrapped to 16 bits.
  - For every mode other than 15, `pc_next = pc_reg` at `done`.
- R12: Mode codes 16–31 are unsupported. They produce `done` one cycle after acceptance with `err` high, zero addresses, zero idle cycles and zero `pc_next`. They issue no pointer request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken in idle |
| mode | input | 5 | Addressing-mode code (0–15 supported) |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| op_bank | input | 8 | Third operand byte (long modes) |
| dp_reg | input | 16 | Direct-page base |
| db_reg | input | 8 | Data bank |
| pb_reg | input | 8 | Program bank |
| pc_reg | input | 16 | Program counter of the immediate operand |
| sp_reg | input | 16 | Stack pointer |
| x_reg | input | 16 | X index |
| y_reg | input | 16 | Y index |
| acc8 | input | 1 | Accumulator is 8 bits wide |
| idx8 | input | 1 | Index registers are 8 bits wide |
| imm_index | input | 1 | Immediate width follows the index flag |
| wr_access | input | 1 | The access is a write |
| ptr_req | output | 1 | Pointer byte request |
| ptr_addr | output | 24 | Pointer byte address (bank 0) |
| ptr_valid | input | 1 | Pointer byte on `ptr_data` is valid |
| ptr_data | input | 8 | Returned pointer byte |
| done | output | 1 | Result valid for one cycle |
| err | output | 1 | Unsupported mode code |
| addr_lo | output | 24 | Address of the operand low byte |
| addr_hi | output | 24 | Address of the operand high byte |
| idle_cycles | output | 2 | Internal cycles the mode costs |
| pc_next | output | 16 | Program counter after immediate bytes |

## Verification
For modes without a pointer, the result is due in the cycle right after the accepting edge. For indirect modes, it is due in the cycle after the edge that takes the last pointer byte. The bench records the cycle number when it raises `start` and when it hands over a final pointer byte. The monitor compares the cycle in which `done` appears against that record. Pointer requests are answered from a computed memory image, sometimes with a stall cycle between bytes, and each request address is compared against the expected queue. A second `start` raised during a fetch must produce no extra result.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 24;
    localparam int MODE_W = 5;
    localparam int IDLE_W = 2;
    localparam int PTR_LANES = ADDR_W / BYTE_W;

    typedef enum logic [MODE_W-1:0] {
        M_DP  = 5'd0,
        M_DPX = 5'd1,
        M_DPY = 5'd2,
        M_ABS = 5'd3,
        M_ABX = 5'd4,
        M_ABY = 5'd5,
        M_ABL = 5'd6,
        M_ALX = 5'd7,
        M_IDX = 5'd8,
        M_IDP = 5'd9,
        M_IDY = 5'd10,
        M_IDL = 5'd11,
        M_ILY = 5'd12,
        M_SR  = 5'd13,
        M_ISY = 5'd14,
        M_IMM = 5'd15
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR_LO,
        S_PTR_HI,
        S_PTR_BANK,
        S_DONE
    } state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [BYTE_W-1:0] op_lo;
        logic [BYTE_W-1:0] op_hi;
        logic [BYTE_W-1:0] op_bank;
        logic [BYTE_W-1:0] db;
        logic [BYTE_W-1:0] pb;
        logic [WORD_W-1:0] dp;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] xr;
        logic [WORD_W-1:0] yr;
        logic [WORD_W-1:0] pc;
        logic              m8;
        logic              x8;
        logic              imm_idx;
        logic              wr;
    } req_t;

    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        return m <= M_IMM;
    endfunction

    function automatic logic [1:0] ptr_bytes(input logic [MODE_W-1:0] m);
        logic [1:0] n;
        case (m)
            M_IDX, M_IDP, M_IDY, M_ISY: n = 2'd2;
            M_IDL, M_ILY:               n = 2'd3;
            default:                    n = 2'd0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/eag_ptr_locator.sv
module eag_ptr_locator
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [WORD_W-1:0] dp,
    input  logic [WORD_W-1:0] sp,
    input  logic [WORD_W-1:0] xr,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [1:0]        byte_idx,
    output logic [ADDR_W-1:0] fetch_addr
);
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] offs;

    always_comb begin
        case (mode)
            M_IDX:   base = dp + WORD_W'(op_lo) + xr;
            M_ISY:   base = sp + WORD_W'(op_lo);
            default: base = dp + WORD_W'(op_lo);
        endcase
        offs = base + WORD_W'(byte_idx);
        fetch_addr = {{(ADDR_W-WORD_W){1'b0}}, offs};
    end
endmodule

// File: rtl/eag_idle_cost.sv
module eag_idle_cost
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [BYTE_W-1:0] dp_lo,
    input  logic [WORD_W-1:0] abs_base,
    input  logic [WORD_W-1:0] ptr16,
    input  logic [WORD_W-1:0] xr,
    input  logic [WORD_W-1:0] yr,
    input  logic              x8,
    input  logic              wr,
    output logic [IDLE_W-1:0] idle
);
    logic dp_pen;
    logic abx_pen;
    logic aby_pen;
    logic idy_pen;

    function automatic logic index_penalty(input logic [WORD_W-1:0] base,
                                           input logic [WORD_W-1:0] idx,
                                           input logic w,
                                           input logic narrow);
        logic [WORD_W:0] sum;
        sum = {1'b0, base} + {1'b0, idx};
        return w | ~narrow | (sum[WORD_W:BYTE_W] != {1'b0, base[WORD_W-1:BYTE_W]});
    endfunction

    always_comb begin
        dp_pen  = |dp_lo;
        abx_pen = index_penalty(abs_base, xr, wr, x8);
        aby_pen = index_penalty(abs_base, yr, wr, x8);
        idy_pen = index_penalty(ptr16, yr, wr, x8);
        case (mode)
            M_DP, M_IDP, M_IDL, M_ILY: idle = IDLE_W'(dp_pen);
            M_DPX, M_DPY, M_IDX:       idle = IDLE_W'(dp_pen) + IDLE_W'(1);
            M_ABX:                     idle = IDLE_W'(abx_pen);
            M_ABY:                     idle = IDLE_W'(aby_pen);
            M_IDY:                     idle = IDLE_W'(dp_pen) + IDLE_W'(idy_pen);
            M_SR:                      idle = IDLE_W'(1);
            M_ISY:                     idle = IDLE_W'(2);
            default:                   idle = '0;
        endcase
    end
endmodule

// File: rtl/eag_addr_math.sv
module eag_addr_math
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [BYTE_W-1:0] op_hi,
    input  logic [BYTE_W-1:0] op_bank,
    input  logic [BYTE_W-1:0] db,
    input  logic [BYTE_W-1:0] pb,
    input  logic [WORD_W-1:0] dp,
    input  logic [WORD_W-1:0] sp,
    input  logic [WORD_W-1:0] xr,
    input  logic [WORD_W-1:0] yr,
    input  logic [WORD_W-1:0] pc,
    input  logic              m8,
    input  logic              x8,
    input  logic              imm_idx,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi,
    output logic [WORD_W-1:0] pc_next
);
    localparam int BANK_PAD = ADDR_W - WORD_W;

    logic [WORD_W-1:0] dp_sum;
    logic [WORD_W-1:0] short_sum;
    logic [WORD_W-1:0] abs_base;
    logic [ADDR_W-1:0] db_bank;
    logic [ADDR_W-1:0] long_op;
    logic [ADDR_W-1:0] ptr_word;
    logic              wrap16;
    logic              imm_wide;

    always_comb begin
        dp_sum   = dp + WORD_W'(op_lo);
        abs_base = {op_hi, op_lo};
        db_bank  = {db, {WORD_W{1'b0}}};
        long_op  = {op_bank, op_hi, op_lo};
        ptr_word = {{BANK_PAD{1'b0}}, ptr[WORD_W-1:0]};
        imm_wide = imm_idx ? ~x8 : ~m8;
        short_sum = dp_sum;
        wrap16   = 1'b0;
        lo       = '0;
        case (mode)
            M_DP:  begin short_sum = dp_sum;      wrap16 = 1'b1; end
            M_DPX: begin short_sum = dp_sum + xr; wrap16 = 1'b1; end
            M_DPY: begin short_sum = dp_sum + yr; wrap16 = 1'b1; end
            M_SR:  begin short_sum = sp + WORD_W'(op_lo); wrap16 = 1'b1; end
            M_ABS: lo = db_bank + ADDR_W'(abs_base);
            M_ABX: lo = db_bank + ADDR_W'(abs_base) + ADDR_W'(xr);
            M_ABY: lo = db_bank + ADDR_W'(abs_base) + ADDR_W'(yr);
            M_ABL: lo = long_op;
            M_ALX: lo = long_op + ADDR_W'(xr);
            M_IDX, M_IDP: lo = db_bank + ptr_word;
            M_IDY, M_ISY: lo = db_bank + ptr_word + ADDR_W'(yr);
            M_IDL: lo = ptr;
            M_ILY: lo = ptr + ADDR_W'(yr);
            M_IMM: lo = {pb, pc};
            default: lo = '0;
        endcase
        if (wrap16) begin
            lo = {{BANK_PAD{1'b0}}, short_sum};
            hi = {{BANK_PAD{1'b0}}, short_sum + WORD_W'(1)};
        end else begin
            hi = lo + ADDR_W'(1);
        end
        pc_next = pc;
        if (mode == M_IMM) begin
            hi      = imm_wide ? {pb, pc + WORD_W'(1)} : '0;
            pc_next = pc + (imm_wide ? WORD_W'(2) : WORD_W'(1));
        end
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [BYTE_W-1:0] op_hi,
    input  logic [BYTE_W-1:0] op_bank,
    input  logic [WORD_W-1:0] dp_reg,
    input  logic [BYTE_W-1:0] db_reg,
    input  logic [BYTE_W-1:0] pb_reg,
    input  logic [WORD_W-1:0] pc_reg,
    input  logic [WORD_W-1:0] sp_reg,
    input  logic [WORD_W-1:0] x_reg,
    input  logic [WORD_W-1:0] y_reg,
    input  logic              acc8,
    input  logic              idx8,
    input  logic              imm_index,
    input  logic              wr_access,
    output logic              ptr_req,
    output logic [ADDR_W-1:0] ptr_addr,
    input  logic              ptr_valid,
    input  logic [BYTE_W-1:0] ptr_data,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic [IDLE_W-1:0] idle_cycles,
    output logic [WORD_W-1:0] pc_next
);
    state_e            state_q;
    state_e            state_d;
    req_t              req_q;
    req_t              req_in;
    logic              accept;
    logic [ADDR_W-1:0] ptr_q;
    logic [1:0]        byte_idx;
    logic [ADDR_W-1:0] loc_addr;
    logic [ADDR_W-1:0] calc_lo;
    logic [ADDR_W-1:0] calc_hi;
    logic [WORD_W-1:0] calc_pc;
    logic [IDLE_W-1:0] calc_idle;

    assign req_in = '{mode: mode, op_lo: op_lo, op_hi: op_hi, op_bank: op_bank,
                      db: db_reg, pb: pb_reg, dp: dp_reg, sp: sp_reg,
                      xr: x_reg, yr: y_reg, pc: pc_reg, m8: acc8, x8: idx8,
                      imm_idx: imm_index, wr: wr_access};

    assign accept = (state_q == S_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = (ptr_bytes(mode) != 2'd0) ? S_PTR_LO : S_DONE;
                end
            end
            S_PTR_LO: begin
                if (ptr_valid) state_d = S_PTR_HI;
            end
            S_PTR_HI: begin
                if (ptr_valid) begin
                    state_d = (ptr_bytes(req_q.mode) == 2'd3) ? S_PTR_BANK : S_DONE;
                end
            end
            S_PTR_BANK: begin
                if (ptr_valid) state_d = S_DONE;
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (accept) begin
            req_q <= req_in;
        end
    end

    // pointer byte lanes
    for (genvar g = 0; g < PTR_LANES; g++) begin : g_lane
        logic lane_load;
        assign lane_load = ptr_req && ptr_valid && (byte_idx == 2'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (accept) begin
                ptr_q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (lane_load) begin
                ptr_q[g*BYTE_W +: BYTE_W] <= ptr_data;
            end
        end
    end

    eag_ptr_locator u_loc (
        .mode       (req_q.mode),
        .dp         (req_q.dp),
        .sp         (req_q.sp),
        .xr         (req_q.xr),
        .op_lo      (req_q.op_lo),
        .byte_idx   (byte_idx),
        .fetch_addr (loc_addr)
    );

    eag_addr_math u_math (
        .mode    (req_q.mode),
        .op_lo   (req_q.op_lo),
        .op_hi   (req_q.op_hi),
        .op_bank (req_q.op_bank),
        .db      (req_q.db),
        .pb      (req_q.pb),
        .dp      (req_q.dp),
        .sp      (req_q.sp),
        .xr      (req_q.xr),
        .yr      (req_q.yr),
        .pc      (req_q.pc),
        .m8      (req_q.m8),
        .x8      (req_q.x8),
        .imm_idx (req_q.imm_idx),
        .ptr     (ptr_q),
        .lo      (calc_lo),
        .hi      (calc_hi),
        .pc_next (calc_pc)
    );

    eag_idle_cost u_idle (
        .mode     (req_q.mode),
        .dp_lo    (req_q.dp[BYTE_W-1:0]),
        .abs_base ({req_q.op_hi, req_q.op_lo}),
        .ptr16    (ptr_q[WORD_W-1:0]),
        .xr       (req_q.xr),
        .yr       (req_q.yr),
        .x8       (req_q.x8),
        .wr       (req_q.wr),
        .idle     (calc_idle)
    );

    // outputs
    always_comb begin
        ptr_req     = 1'b0;
        byte_idx    = 2'd0;
        ptr_addr    = '0;
        done        = 1'b0;
        err         = 1'b0;
        addr_lo     = '0;
        addr_hi     = '0;
        idle_cycles = '0;
        pc_next     = '0;
        unique case (state_q)
            S_IDLE: ;
            S_PTR_LO: begin
                ptr_req  = 1'b1;
                byte_idx = 2'd0;
                ptr_addr = loc_addr;
            end
            S_PTR_HI: begin
                ptr_req  = 1'b1;
                byte_idx = 2'd1;
                ptr_addr = loc_addr;
            end
            S_PTR_BANK: begin
                ptr_req  = 1'b1;
                byte_idx = 2'd2;
                ptr_addr = loc_addr;
            end
            S_DONE: begin
                done = 1'b1;
                if (mode_known(req_q.mode)) begin
                    addr_lo     = calc_lo;
                    addr_hi     = calc_hi;
                    idle_cycles = calc_idle;
                    pc_next     = calc_pc;
                end else begin
                    err = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eag_unit_checks.sv
module eag_unit_checks
    import eag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_req,
    input logic              ptr_valid,
    input logic [ADDR_W-1:0] ptr_addr,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] addr_lo,
    input logic [ADDR_W-1:0] addr_hi,
    input logic [IDLE_W-1:0] idle_cycles,
    input logic [WORD_W-1:0] pc_next
);
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_quiet_results: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (addr_lo == '0 && addr_hi == '0 && idle_cycles == '0
                   && pc_next == '0 && !err));

    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && !ptr_valid) |=> (ptr_req && $stable(ptr_addr)));

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req |-> !done);

    a_r2_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req |-> (ptr_addr[ADDR_W-1:WORD_W] == '0));

    a_r2_done_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !ptr_req);

    a_r10_idle_limit: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (idle_cycles != 2'd3));

    a_r12_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && idle_cycles == '0 && addr_lo == '0 && addr_hi == '0));
endmodule

bind eag_unit eag_unit_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ptr_req     (ptr_req),
    .ptr_valid   (ptr_valid),
    .ptr_addr    (ptr_addr),
    .done        (done),
    .err         (err),
    .addr_lo     (addr_lo),
    .addr_hi     (addr_hi),
    .idle_cycles (idle_cycles),
    .pc_next     (pc_next)
);

// File: tb/eag_unit_test.sv
`timescale 1ns/1ps
module eag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  mode = '0;
    logic [7:0]  op_lo = '0, op_hi = '0, op_bank = '0, db_reg = '0, pb_reg = '0;
    logic [15:0] dp_reg = '0, pc_reg = '0, sp_reg = '0, x_reg = '0, y_reg = '0;
    logic        acc8 = 1'b0, idx8 = 1'b0, imm_index = 1'b0, wr_access = 1'b0;
    logic        ptr_req;
    logic [23:0] ptr_addr;
    logic        ptr_valid = 1'b0;
    logic [7:0]  ptr_data = '0;
    logic        done, err;
    logic [23:0] addr_lo, addr_hi;
    logic [1:0]  idle_cycles;
    logic [15:0] pc_next;

    typedef struct {
        int    lo, hi, idle, pcn, nptr;
        bit    er;
        string tag, itag;
    } exp_t;

    exp_t exq[$];
    int   ptrq[$];
    int   total = 0, bad = 0, cyc = 0, start_cyc = 0, resp_cyc = 0;
    bit   stall_on = 1'b0, phase = 1'b0;

    eag_unit uut (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int mem_at(int a);
        logic [7:0] v;
        v = ((8'(a) * 8'd3) + 8'(a >> 8)) ^ 8'hA5;
        return int'(v);
    endfunction

    function automatic bit pen(int base, int idx);
        return wr_access || !idx8 || ((base >> 8) != ((base + idx) >> 8));
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic setup(int m, int ol, int oh, int ob, int d, int db, int pb,
                         int pc, int sp, int x, int y, bit mf, bit xf, bit ix, bit wr);
        mode = 5'(m); op_lo = 8'(ol); op_hi = 8'(oh); op_bank = 8'(ob);
        dp_reg = 16'(d); db_reg = 8'(db); pb_reg = 8'(pb); pc_reg = 16'(pc);
        sp_reg = 16'(sp); x_reg = 16'(x); y_reg = 16'(y);
        acc8 = mf; idx8 = xf; imm_index = ix; wr_access = wr;
    endtask

    // driver: computes the expected item from the requirements, then strobes start
    task automatic launch(bit poke);
        exp_t e;
        int m = mode, op = op_lo, b16 = {op_hi, op_lo}, d = dp_reg, db = db_reg;
        int x = x_reg, y = y_reg, pbase = 0, p = 0, lo = 0;
        bit w16 = 0, dpp = (dp_reg[7:0] != 0), wide;
        e.nptr = 0; e.idle = 0; e.er = 0; e.pcn = pc_reg; e.hi = 0;
        e.tag = "R3"; e.itag = "R4";
        case (m)
            0: begin lo = (d + op) & 'hffff; w16 = 1; e.idle = dpp; end
            1: begin lo = (d + op + x) & 'hffff; w16 = 1; e.idle = dpp + 1; end
            2: begin lo = (d + op + y) & 'hffff; w16 = 1; e.idle = dpp + 1; end
            3: begin e.tag = "R5"; e.itag = "R5"; lo = (db << 16) + b16; end
            4: begin e.tag = "R5"; e.itag = "R6"; lo = ((db << 16) + b16 + x) & 'hffffff; e.idle = pen(b16, x); end
            5: begin e.tag = "R5"; e.itag = "R6"; lo = ((db << 16) + b16 + y) & 'hffffff; e.idle = pen(b16, y); end
            6: begin e.tag = "R7"; e.itag = "R7"; lo = (op_bank << 16) | b16; end
            7: begin e.tag = "R7"; e.itag = "R7"; lo = (((op_bank << 16) | b16) + x) & 'hffffff; end
            8, 9, 10: begin e.tag = "R8"; pbase = (d + op + (m == 8 ? x : 0)) & 'hffff; e.nptr = 2; end
            11, 12: begin e.tag = "R9"; pbase = (d + op) & 'hffff; e.nptr = 3; e.idle = dpp; end
            13: begin e.tag = "R10"; e.itag = "R10"; lo = (sp_reg + op) & 'hffff; w16 = 1; e.idle = 1; end
            14: begin e.tag = "R10"; e.itag = "R10"; pbase = (sp_reg + op) & 'hffff; e.nptr = 2; e.idle = 2; end
            15: begin
                e.tag = "R11"; e.itag = "R11";
                wide = imm_index ? !idx8 : !acc8;
                lo = (pb_reg << 16) | pc_reg;
                e.hi = wide ? ((pb_reg << 16) | ((pc_reg + 1) & 'hffff)) : 0;
                e.pcn = (pc_reg + (wide ? 2 : 1)) & 'hffff;
            end
            default: begin e.tag = "R12"; e.itag = "R12"; e.er = 1; e.pcn = 0; end
        endcase
        for (int k = 0; k < e.nptr; k++) begin
            ptrq.push_back((pbase + k) & 'hffff);
            p |= mem_at((pbase + k) & 'hffff) << (8 * k);
        end
        case (m)
            8:  begin lo = (db << 16) + (p & 'hffff); e.idle = dpp + 1; end
            9:  begin lo = (db << 16) + (p & 'hffff); e.idle = dpp; end
            10: begin lo = ((db << 16) + (p & 'hffff) + y) & 'hffffff; e.idle = dpp + pen(p & 'hffff, y); e.itag = "R6"; end
            11: lo = p;
            12: lo = (p + y) & 'hffffff;
            14: lo = ((db << 16) + (p & 'hffff) + y) & 'hffffff;
            default: ;
        endcase
        e.lo = lo;
        if (m < 15) e.hi = w16 ? ((lo + 1) & 'hffff) : ((lo + 1) & 'hffffff);
        exq.push_back(e);
        @(negedge clk); start = 1'b1; start_cyc = cyc;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            mode = 5'd0; op_lo = 8'h77; start = 1'b1;
            @(negedge clk); @(negedge clk); start = 1'b0;
        end
        while (exq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R1", "quiet done", int'(done), 0);
    endtask

    // pointer responder
    always @(negedge clk) begin
        phase = ~phase;
        if (rst_n && ptr_req && !(stall_on && phase)) begin
            ptr_valid = 1'b1;
            ptr_data  = 8'(mem_at(int'(ptr_addr)));
            if (ptrq.size() == 0) begin
                chk("R2", "unexpected ptr_req", 1, 0);
            end else begin
                chk("R2", "ptr_addr", int'(ptr_addr), ptrq.pop_front());
                if (ptrq.size() == 0) resp_cyc = cyc;
            end
        end else begin
            ptr_valid = 1'b0;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exq.size() == 0) begin
                chk("R1", "done without request", 1, 0);
            end else begin
                exp_t e;
                e = exq.pop_front();
                if (e.nptr == 0) chk("R1", "done timing", cyc, start_cyc + 1);
                else             chk("R2", "done timing", cyc, resp_cyc + 1);
                chk(e.tag, "addr_lo", int'(addr_lo), e.lo);
                chk(e.tag, "addr_hi", int'(addr_hi), e.hi);
                chk(e.itag, "idle_cycles", int'(idle_cycles), e.idle);
                chk(e.tag, "err", int'(err), int'(e.er));
                chk(e.tag, "pc_next", int'(pc_next), e.pcn);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset ptr_req", int'(ptr_req), 0);
        chk("R1", "reset addr_lo", int'(addr_lo), 0);
        // R3 / R4 direct page
        setup(0, 'h34, 0, 0, 'h1200, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0); launch(0);
        setup(0, 'h34, 0, 0, 'h1201, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0); launch(0);
        setup(0, 'h0F, 0, 0, 'hFFF0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0); launch(0);
        setup(1, 'h10, 0, 0, 'h0100, 0, 0, 0, 0, 5, 0, 1, 1, 0, 0); launch(0);
        setup(1, 'h10, 0, 0, 'h0180, 0, 0, 0, 0, 'hFFFF, 0, 1, 1, 0, 0); launch(0);
        setup(2, 'h02, 0, 0, 'h2300, 0, 0, 0, 0, 0, 'h40, 1, 1, 0, 0); launch(0);
        // R5 / R6 absolute
        setup(3, 'h34, 'h12, 0, 0, 'h7E, 0, 0, 0, 0, 0, 1, 1, 0, 0); launch(0);
        setup(3, 'hFF, 'hFF, 0, 0, 'hFF, 0, 0, 0, 0, 0, 1, 1, 0, 0); launch(0);
        setup(4, 'h10, 'h12, 0, 0, 'h01, 0, 0, 0, 5, 0, 1, 1, 0, 0); launch(0);
        setup(4, 'hFE, 'h12, 0, 0, 'h01, 0, 0, 0, 5, 0, 1, 1, 0, 0); launch(0);
        setup(4, 'h10, 'h12, 0, 0, 'h01, 0, 0, 0, 5, 0, 1, 1, 0, 1); launch(0);
        setup(5, 'h10, 'h12, 0, 0, 'hFF, 0, 0, 0, 0, 'hFFFF, 1, 0, 0, 0); launch(0);
        // R7 long
        setup(6, 'h56, 'h34, 'h12, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0); launch(0);
        setup(7, 'hF0, 'hFF, 'hFF, 0, 0, 0, 0, 0, 'h20, 0, 1, 1, 0, 0); launch(0);
        // R8 / R9 indirect, with and without stalls
        setup(8, 'h20, 0, 0, 'h0010, 'h7F, 0, 0, 0, 3, 0, 1, 1, 0, 0); launch(0);
        stall_on = 1'b1;
        setup(8, 'h20, 0, 0, 'h0011, 'h7F, 0, 0, 0, 3, 0, 1, 1, 0, 0); launch(0);
        setup(9, 'h40, 0, 0, 'h0300, 'hFF, 0, 0, 0, 0, 0, 1, 1, 0, 0); launch(0);
        setup(10, 'h40, 0, 0, 'h0300, 'h12, 0, 0, 0, 0, 'h00F0, 1, 1, 0, 0); launch(0);
        setup(10, 'h40, 0, 0, 'h0305, 'h12, 0, 0, 0, 0, 'h0001, 1, 1, 0, 1); launch(0);
        setup(11, 'h01, 0, 0, 'hFFFE, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0); launch(1);
        stall_on = 1'b0;
        setup(12, 'h10, 0, 0, 'h4400, 0, 0, 0, 0, 0, 'hFFFF, 1, 1, 0, 0); launch(0);
        // R10 stack relative
        setup(13, 'h20, 0, 0, 0, 0, 0, 0, 'hFFF0, 0, 0, 1, 1, 0, 0); launch(0);
        setup(14, 'h03, 0, 0, 0, 'h7E, 0, 0, 'h01F0, 0, 'h0010, 1, 1, 0, 0); launch(0);
        // R11 immediate
        setup(15, 0, 0, 0, 0, 0, 'h80, 'h1000, 0, 0, 0, 1, 0, 0, 0); launch(0);
        setup(15, 0, 0, 0, 0, 0, 'h80, 'h1000, 0, 0, 0, 0, 1, 0, 0); launch(0);
        setup(15, 0, 0, 0, 0, 0, 'h80, 'h1000, 0, 0, 0, 0, 1, 1, 0); launch(0);
        setup(15, 0, 0, 0, 0, 0, 'h3F, 'hFFFF, 0, 0, 0, 1, 0, 1, 0); launch(0);
        // R12 unsupported codes
        setup(16, 'h11, 'h22, 'h33, 'h1201, 'h44, 'h55, 'h6666, 0, 1, 1, 0, 0, 0, 1); launch(0);
        setup(31, 'h11, 'h22, 'h33, 'h1201, 'h44, 'h55, 'h6666, 0, 1, 1, 0, 0, 0, 1); launch(0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule